// File: doc/BRIEF.md
# Gray-Domain Up/Down Step Counter

This block is a synchronous counter whose state is a reflected binary Gray word. It never holds a binary count. Each enabled cycle it works out the next code inside the Gray domain and flips exactly one bit of the word. A registered parity bit travels with the count. Together with the direction input, that bit decides which bit to flip:

- When the parity calls for it, the least significant bit flips.
- Otherwise the bit directly above the lowest set bit flips. A zero-detect chain running upward from bit 0 finds that bit.

Because only one bit moves per step, the output can be sampled safely in another clock domain. It can also serve as a low-switching-activity address sequence. The width is a parameter of at least two bits and defaults to 16.

Top module: `gud_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter loads `gray_q` = 0 and `parity_q` = 0, whatever `step_en` and `count_up` are.
- R2: With `rst` low and `step_en` low, `gray_q` and `parity_q` keep their values across the edge.
- R3: With `step_en` high and `count_up` = 1, `gray_q` moves to the Gray code of (binary value + 1), where the Gray code of b is b XOR (b >> 1).
- R4: With `step_en` high and `count_up` = 0, `gray_q` moves to the Gray code of (binary value − 1).
- R5: Every enabled step changes exactly one bit of `gray_q`.
- R6: `parity_q` always equals the XOR of all bits of `gray_q`, which is the LSB of the equivalent binary value. It therefore inverts on every enabled step.
- R7: Counting up from the top code (only the MSB set) wraps to all zeros.
- R8: Counting down from all zeros wraps to the top code (only the MSB set).
- R9: A change of `count_up` between two enabled cycles takes effect at the very next edge, with no lost or extra step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the count this cycle |
| count_up | input | 1 | 1 = increment, 0 = decrement |
| gray_q | output | W | Registered Gray count |
| parity_q | output | 1 | Registered parity of `gray_q` |

## Verification
Two pairs of functions can land on the same clock edge:

- **Reset against an enabled step.** The bench raises `rst` with `step_en` high in both directions. It then expects the zero state rather than a stepped value.
- **A wrap against a direction reversal.** The bench reverses `count_up` right at the top code and right at zero, so the wrap logic and the reversed parity rule are exercised in the same cycle. The result is compared against a binary reference model that is converted to Gray.

A 5-bit instance is swept through full cycles in both directions and through pseudo-random enable and direction patterns.

// File: rtl/gud_pkg.sv
package gud_pkg;
  // direction encoding on count_up
  typedef enum logic {
    GUD_DOWN = 1'b0,
    GUD_UP   = 1'b1
  } gud_dir_e;

  // selects LSB toggle vs. scan toggle: scan when parity differs from
  // what an increment from an even word would need
  function automatic logic gud_use_scan(input logic par, input gud_dir_e dir);
    return par ^ (dir == GUD_DOWN);
  endfunction
endpackage

// File: rtl/gud_zero_scan.sv
// Finds the bit just above the lowest set bit of a Gray word by a
// zero-detect chain rising from bit 0. A lowest set bit at the MSB maps
// onto the MSB itself (wrap).
module gud_zero_scan #(
  parameter int W = 16
) (
  input  logic [W-1:0] word,
  output logic [W-1:0] above_low,
  output logic         all_zero
);
  logic [W:0] clear_below;

  assign clear_below[0] = 1'b1;
  assign above_low[0]   = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign clear_below[i+1] = clear_below[i] & ~word[i];
  end

  for (genvar i = 1; i < W - 1; i++) begin : g_mid
    assign above_low[i] = word[i-1] & clear_below[i-1];
  end

  assign above_low[W-1] = (word[W-2] & clear_below[W-2]) |
                          (word[W-1] & clear_below[W-1]);
  assign all_zero = clear_below[W];
endmodule

// File: rtl/gud_step_select.sv
// Builds the one-hot toggle mask from parity, direction and scan result.
module gud_step_select
  import gud_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         par,
  input  gud_dir_e     dir,
  input  logic [W-1:0] scan_mask,
  input  logic         word_zero,
  output logic [W-1:0] step_mask,
  output logic         use_scan
);
  localparam logic [W-1:0] LSB_HOT = W'(1);
  localparam logic [W-1:0] MSB_HOT = LSB_HOT << (W - 1);

  always_comb begin
    use_scan = gud_use_scan(par, dir);
    if (!use_scan)
      step_mask = LSB_HOT;
    else if (word_zero)
      step_mask = MSB_HOT;
    else
      step_mask = scan_mask;
  end
endmodule

// File: rtl/gud_counter.sv
module gud_counter
  import gud_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         count_up,
  output logic [W-1:0] gray_q,
  output logic         parity_q
);
  if (W < 2) begin : g_bad_width
    initial $error("gud_counter: W must be at least 2");
  end

  logic [W-1:0] scan_mask;
  logic         word_zero;
  logic [W-1:0] step_mask;
  logic         use_scan;
  gud_dir_e     dir;

  assign dir = gud_dir_e'(count_up);

  gud_zero_scan #(.W(W)) u_scan (
    .word      (gray_q),
    .above_low (scan_mask),
    .all_zero  (word_zero)
  );

  gud_step_select #(.W(W)) u_sel (
    .par       (parity_q),
    .dir       (dir),
    .scan_mask (scan_mask),
    .word_zero (word_zero),
    .step_mask (step_mask),
    .use_scan  (use_scan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gray_q   <= '0;
      parity_q <= 1'b0;
    end else if (step_en) begin
      gray_q   <= gray_q ^ step_mask;
      parity_q <= ~parity_q;
    end
  end
endmodule

// File: rtl/gud_counter_chk.sv
module gud_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         step_en,
  input logic         count_up,
  input logic [W-1:0] gray_q,
  input logic         parity_q,
  input logic [W-1:0] step_mask
);
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (gray_q == '0) && !parity_q);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(gray_q) && $stable(parity_q));

  // R5
  single_flip_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> $countones(gray_q ^ $past(gray_q)) == 1);

  // R5
  mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(step_mask) == 1);

  // R6
  parity_match_chk: assert property (@(posedge clk) disable iff (rst)
    parity_q == ^gray_q);

  // R7
  wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    step_en && count_up && gray_q == TOP |=> gray_q == '0);

  // R8
  wrap_down_chk: assert property (@(posedge clk) disable iff (rst)
    step_en && !count_up && gray_q == '0 |=> gray_q == TOP);
endmodule

bind gud_counter gud_counter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step_en   (step_en),
  .count_up  (count_up),
  .gray_q    (gray_q),
  .parity_q  (parity_q),
  .step_mask (step_mask)
);

// File: tb/gud_counter_test.sv
module gud_counter_test;
  localparam int W = 5;
  localparam logic [W-1:0] MAXB = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic count_up = 1'b1;
  logic [W-1:0] gray_q;
  logic parity_q;

  int vectors = 0;
  int fails = 0;
  logic [W-1:0] ref_bin = '0;
  logic last_dir = 1'b1;

  always #4 clk = ~clk;

  gud_counter #(.W(W)) uut (
    .clk(clk), .rst(rst), .step_en(step_en), .count_up(count_up),
    .gray_q(gray_q), .parity_q(parity_q)
  );

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic apply(input logic r, input logic e, input logic u);
    logic [W-1:0] prev_g;
    logic [W-1:0] old_b;
    string tag;
    prev_g = gray_q;
    old_b = ref_bin;
    rst = r; step_en = e; count_up = u;
    if (r) tag = "R1";
    else if (!e) tag = "R2";
    else if (u && old_b == MAXB) tag = "R7";
    else if (!u && old_b == '0) tag = "R8";
    else if (u != last_dir) tag = "R9";
    else tag = u ? "R3" : "R4";
    if (r) ref_bin = '0;
    else if (e) begin
      ref_bin = u ? old_b + 1'b1 : old_b - 1'b1;
      last_dir = u;
    end
    @(negedge clk);
    vectors++;
    if (gray_q !== to_gray(ref_bin)) begin
      fails++;
      $display("FAIL %s count: actual %b expected %b", tag, gray_q, to_gray(ref_bin));
    end
    vectors++;
    if (parity_q !== ref_bin[0]) begin
      fails++;
      $display("FAIL R6 parity: actual %b expected %b", parity_q, ref_bin[0]);
    end
    if (e && !r) begin
      vectors++;
      if ($countones(gray_q ^ prev_g) != 1) begin
        fails++;
        $display("FAIL R5 bits changed: actual %0d expected 1",
                 $countones(gray_q ^ prev_g));
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    @(negedge clk);
    apply(1'b1, 1'b0, 1'b1);            // R1 reset state
    for (int i = 0; i < 70; i++) apply(1'b0, 1'b1, 1'b1);   // R3 / R7
    for (int i = 0; i < 5; i++)  apply(1'b0, 1'b0, 1'b0);   // R2 hold
    for (int i = 0; i < 70; i++) apply(1'b0, 1'b1, 1'b0);   // R4 / R8
    // R9 reversal right at the wrap points
    while (ref_bin != MAXB) apply(1'b0, 1'b1, 1'b1);
    apply(1'b0, 1'b1, 1'b0);
    apply(1'b0, 1'b1, 1'b1);
    apply(1'b0, 1'b1, 1'b1);            // R7 wrap to zero
    apply(1'b0, 1'b1, 1'b0);            // R8 wrap with reversal
    apply(1'b0, 1'b1, 1'b1);
    // R9 alternating direction with growing run lengths
    for (int k = 1; k < 8; k++) begin
      for (int j = 0; j < k; j++) apply(1'b0, 1'b1, 1'b1);
      for (int j = 0; j < k + 1; j++) apply(1'b0, 1'b1, 1'b0);
    end
    // R1 reset in the same cycle as an enabled step, both directions
    apply(1'b0, 1'b1, 1'b1);
    apply(1'b1, 1'b1, 1'b1);
    apply(1'b0, 1'b1, 1'b1);
    apply(1'b1, 1'b1, 1'b0);
    // pseudo-random enable / direction
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[7:0] == 8'h00, lfsr[3] | lfsr[5], lfsr[9]);
    end
    report();
  end
endmodule